// File: doc/BRIEF.md
# Event-Driven PWM Output Generator

This block produces a single pulse-width-modulated output from a free-running counter and two compare values. The counter runs in one of two modes. In count-down mode it steps from the load value down to zero and then reloads. In up/down mode it climbs from zero to the load value and falls back again. The counter's value is decoded into six event pulses: reaching zero, reaching the load value, and a match on compare A or compare B. Each compare match is tagged with the direction the counter is moving.

A 12-bit action word gives every event a 2-bit effect on the output: keep, invert, force low or force high. When events land in the same cycle, a fixed priority picks the one that acts. Software-facing registers, dead-band insertion, fault handling and interrupts belong to surrounding logic. This block takes its configuration as plain inputs.

Top module: `pwm_event_gen`

## Requirements
- R1: After reset the output is 0, no event pulse is asserted while the block is disabled, and with the action word at all zeros no event ever changes the output.
- R2: In count-down mode (updown_i = 0) the counter takes load_i+1 cycles per period. It raises the zero pulse once per period and the load pulse once per period, and only the down-direction compare pulses occur.
- R3: In up/down mode (updown_i = 1) the counter starts at 0, runs up to load_i and back down, with a period of 2*load_i cycles. All six event pulses can occur.
- R4: Action codes act on the output as follows: 0 keeps it, 1 inverts it, 2 forces it to 0, 3 forces it to 1.
- R5: The action word fields are: zero in bits 1:0, load in bits 3:2, compare A rising in bits 5:4, compare A falling in bits 7:6, compare B rising in bits 9:8, compare B falling in bits 11:10.
- R6: If a zero or load event falls in the same cycle as any compare event, only the zero or load action is applied.
- R7: If compare A and compare B events fall in the same cycle, only the compare B action is applied.
- R8: If zero and load coincide (load_i = 0), the zero action is applied and the load action is dropped.
- R9: Event pulses appear in the cycle the counter holds the matching value, and the output takes the selected action's result on the next clock edge.
- R10: While en_i is 0 no event pulse is raised and the output keeps its value. The counter waits at its start value: load_i in count-down mode, 0 in up/down mode.
- R11: A compare match pulses once per crossing of the compare value. It is flagged as rising when the counter is moving up (including the cycle it sits at load_i in up/down mode) and as falling otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the counter at its start value |
| updown_i | input | 1 | 0 = count-down mode, 1 = up/down mode |
| load_i | input | CNT_W | Load (period) value |
| cmpa_i | input | CNT_W | Compare A value |
| cmpb_i | input | CNT_W | Compare B value |
| act_i | input | 12 | Action word, six 2-bit fields |
| pwm_o | output | 1 | PWM output |
| evt_zero_o | output | 1 | Counter at zero |
| evt_load_o | output | 1 | Counter at load value |
| evt_cmpa_up_o | output | 1 | Compare A match while counting up |
| evt_cmpa_dn_o | output | 1 | Compare A match while counting down |
| evt_cmpb_up_o | output | 1 | Compare B match while counting up |
| evt_cmpb_dn_o | output | 1 | Compare B match while counting down |

## Verification
Event pulses are decoded directly from the count register, so they are due in the same cycle the counter holds the matching value. The output passes through one register and is due one edge after its event. The bench keeps its own model of count, direction and output. It compares all seven outputs at each falling edge, after inputs have settled. It advances its model at the rising edge, so each expected value is checked in the cycle it is due. Dedicated checks confirm the one-edge delay from a zero pulse to the output change. They also count pulses over whole periods to confirm period length and once-per-crossing behaviour.

// File: rtl/pwmg_pkg.sv
// Shared types and helpers for the event-driven PWM generator.
// Assumes the action word holds six 2-bit fields, one per event.
package pwmg_pkg;

    localparam int N_EVT = 6;
    localparam int ACT_W = 2 * N_EVT;

    // Event index, which is also the field index in the action word.
    localparam int EV_ZERO = 0;
    localparam int EV_LOAD = 1;
    localparam int EV_A_UP = 2;
    localparam int EV_A_DN = 3;
    localparam int EV_B_UP = 4;
    localparam int EV_B_DN = 5;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_FLIP = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HIGH = 2'd3
    } act_e;

    typedef struct packed {
        logic b_dn;
        logic b_up;
        logic a_dn;
        logic a_up;
        logic load;
        logic zero;
    } evt_t;

    // Result of one action code applied to the present output level.
    function automatic logic apply_act(act_e code, logic cur);
        logic r;
        case (code)
            ACT_KEEP: r = cur;
            ACT_FLIP: r = ~cur;
            ACT_LOW:  r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmg_counter.sv
// Period counter for the PWM generator.
// Count-down mode: load -> 0, then reload. Up/down mode: 0 -> load -> 0.
// dir_up_o is the direction the counter is moving at the present value.
// Zero and load pulses are decoded from the count register and gated by enable.
// Assumes load_i is held steady while running.
module pwmg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             updown_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             zero_o,
    output logic             load_o
);

    localparam logic [CNT_W-1:0] ZERO_V = '0;
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic             at_zero;
    logic             at_load;
    logic             load_is_zero;

    assign at_zero      = (cnt_q == ZERO_V);
    assign at_load      = (cnt_q >= load_i);
    assign load_is_zero = (load_i == ZERO_V);

    // Advance the count and direction, or park at the start value when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO_V;
            up_q  <= 1'b1;
        end else if (!en_i) begin
            cnt_q <= updown_i ? ZERO_V : load_i;
            up_q  <= updown_i;
        end else if (!updown_i) begin
            up_q  <= 1'b0;
            cnt_q <= at_zero ? load_i : cnt_q - ONE_V;
        end else if (up_q) begin
            if (at_load) begin
                up_q  <= 1'b0;
                cnt_q <= load_is_zero ? ZERO_V : load_i - ONE_V;
            end else begin
                cnt_q <= cnt_q + ONE_V;
            end
        end else begin
            if (at_zero) begin
                up_q  <= 1'b1;
                cnt_q <= load_is_zero ? ZERO_V : ONE_V;
            end else begin
                cnt_q <= cnt_q - ONE_V;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign dir_up_o = up_q;
    assign zero_o   = en_i & at_zero;
    assign load_o   = en_i & (cnt_q == load_i);

endmodule

// File: rtl/pwmg_match.sv
// Compare bank: one equality comparator per compare value.
// Each match is split into a rising-direction and a falling-direction pulse.
// Assumes the counter visits each value once per crossing.
module pwmg_match #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 2
) (
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             dir_up_i,
    input  logic [CNT_W-1:0] cmp_i [N_CMP],
    output logic [N_CMP-1:0] up_o,
    output logic [N_CMP-1:0] dn_o
);

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        logic hit;
        // Equality match, gated by enable.
        always_comb hit = en_i & (cnt_i == cmp_i[g]);
        assign up_o[g] = hit & dir_up_i;
        assign dn_o[g] = hit & ~dir_up_i;
    end

endmodule

// File: rtl/pwmg_action.sv
// Action resolver and output register.
// Picks one event by fixed priority: zero, load, compare B, compare A.
// Applies that event's 2-bit code to the output on the next edge.
// Assumes at most one direction of each compare is active in a cycle.
module pwmg_action
    import pwmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_t             evt_i,
    input  logic [ACT_W-1:0] act_i,
    output logic             pwm_o
);

    logic [1:0] fld [N_EVT];
    act_e       sel;
    logic       pwm_q;

    for (genvar g = 0; g < N_EVT; g++) begin : g_fld
        assign fld[g] = act_i[2*g +: 2];
    end

    // Choose the single acting code by priority.
    always_comb begin
        if (evt_i.zero)      sel = act_e'(fld[EV_ZERO]);
        else if (evt_i.load) sel = act_e'(fld[EV_LOAD]);
        else if (evt_i.b_up) sel = act_e'(fld[EV_B_UP]);
        else if (evt_i.b_dn) sel = act_e'(fld[EV_B_DN]);
        else if (evt_i.a_up) sel = act_e'(fld[EV_A_UP]);
        else if (evt_i.a_dn) sel = act_e'(fld[EV_A_DN]);
        else                 sel = ACT_KEEP;
    end

    // Register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= apply_act(sel, pwm_q);
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_event_gen.sv
// Top of the event-driven PWM generator.
// Ties the counter, compare bank and action resolver together.
// Assumes configuration inputs are steady while enabled.
module pwm_event_gen #(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      updown_i,
    input  logic [CNT_W-1:0]          load_i,
    input  logic [CNT_W-1:0]          cmpa_i,
    input  logic [CNT_W-1:0]          cmpb_i,
    input  logic [pwmg_pkg::ACT_W-1:0] act_i,
    output logic                      pwm_o,
    output logic                      evt_zero_o,
    output logic                      evt_load_o,
    output logic                      evt_cmpa_up_o,
    output logic                      evt_cmpa_dn_o,
    output logic                      evt_cmpb_up_o,
    output logic                      evt_cmpb_dn_o
);

    localparam int N_CMP = 2;

    logic [CNT_W-1:0] cnt;
    logic             dir_up;
    logic             ev_zero;
    logic             ev_load;
    logic [CNT_W-1:0] cmp_arr [N_CMP];
    logic [N_CMP-1:0] m_up;
    logic [N_CMP-1:0] m_dn;
    pwmg_pkg::evt_t   evts;

    assign cmp_arr[0] = cmpa_i;
    assign cmp_arr[1] = cmpb_i;

    pwmg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .updown_i (updown_i),
        .load_i   (load_i),
        .cnt_o    (cnt),
        .dir_up_o (dir_up),
        .zero_o   (ev_zero),
        .load_o   (ev_load)
    );

    pwmg_match #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_match (
        .en_i     (en_i),
        .cnt_i    (cnt),
        .dir_up_i (dir_up),
        .cmp_i    (cmp_arr),
        .up_o     (m_up),
        .dn_o     (m_dn)
    );

    // Gather the six event pulses into one record.
    always_comb begin
        evts.zero = ev_zero;
        evts.load = ev_load;
        evts.a_up = m_up[0];
        evts.a_dn = m_dn[0];
        evts.b_up = m_up[1];
        evts.b_dn = m_dn[1];
    end

    pwmg_action u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evts),
        .act_i (act_i),
        .pwm_o (pwm_o)
    );

    assign evt_zero_o    = evts.zero;
    assign evt_load_o    = evts.load;
    assign evt_cmpa_up_o = evts.a_up;
    assign evt_cmpa_dn_o = evts.a_dn;
    assign evt_cmpb_up_o = evts.b_up;
    assign evt_cmpb_dn_o = evts.b_dn;

endmodule

// File: rtl/pwmg_checker.sv
// Port-level property checker for pwm_event_gen, attached by bind.
module pwmg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             updown_i,
    input logic [11:0]      act_i,
    input logic             pwm_o,
    input logic             evt_zero_o,
    input logic             evt_load_o,
    input logic             evt_cmpa_up_o,
    input logic             evt_cmpa_dn_o,
    input logic             evt_cmpb_up_o,
    input logic             evt_cmpb_dn_o
);

    logic any_evt;
    assign any_evt = evt_zero_o | evt_load_o | evt_cmpa_up_o | evt_cmpa_dn_o
                   | evt_cmpb_up_o | evt_cmpb_dn_o;

    p_reset_low_r1: assert property (@(posedge clk) $rose(rst_n) |-> !pwm_o);

    p_down_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !updown_i) |-> !(evt_cmpa_up_o || evt_cmpb_up_o));

    p_quiet_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> $stable(pwm_o));

    p_zero_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero_o && act_i[1:0] == 2'd3) |=> pwm_o);

    p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_zero_o && act_i[1:0] == 2'd2) |=> !pwm_o);

    p_b_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cmpa_dn_o && evt_cmpb_dn_o && !evt_zero_o && !evt_load_o
         && act_i[11:10] == 2'd3) |=> pwm_o);

    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !any_evt);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(pwm_o));

    p_one_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_cmpa_up_o && evt_cmpa_dn_o) && !(evt_cmpb_up_o && evt_cmpb_dn_o));

endmodule

bind pwm_event_gen pwmg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .updown_i      (updown_i),
    .act_i         (act_i),
    .pwm_o         (pwm_o),
    .evt_zero_o    (evt_zero_o),
    .evt_load_o    (evt_load_o),
    .evt_cmpa_up_o (evt_cmpa_up_o),
    .evt_cmpa_dn_o (evt_cmpa_dn_o),
    .evt_cmpb_up_o (evt_cmpb_up_o),
    .evt_cmpb_dn_o (evt_cmpb_dn_o)
);

// File: tb/sim_pwm_event_gen.sv
// Directed bench for pwm_event_gen with a cycle model built from the requirements.
module sim_pwm_event_gen;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          ud = 1'b0;
    logic [CW-1:0] ld = '0;
    logic [CW-1:0] ca = '0;
    logic [CW-1:0] cb = '0;
    logic [11:0]   act = '0;

    logic pwm, ez, el, eau, ead, ebu, ebd;

    always #4 clk = ~clk;

    pwm_event_gen #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .updown_i(ud),
        .load_i(ld), .cmpa_i(ca), .cmpb_i(cb), .act_i(act),
        .pwm_o(pwm), .evt_zero_o(ez), .evt_load_o(el),
        .evt_cmpa_up_o(eau), .evt_cmpa_dn_o(ead),
        .evt_cmpb_up_o(ebu), .evt_cmpb_dn_o(ebd)
    );

    int vectors = 0;
    int errors  = 0;

    // Model state. Event bit order: 5 zero, 4 load, 3 A up, 2 A dn, 1 B up, 0 B dn.
    logic [CW-1:0] m_cnt;
    logic          m_dir;
    logic          m_pwm;
    logic [5:0]    last_ev;
    int            ev_cnt [6];

    function automatic logic [11:0] mk_act(logic [1:0] z, logic [1:0] l, logic [1:0] au,
                                           logic [1:0] ad, logic [1:0] bu, logic [1:0] bd);
        return {bd, bu, ad, au, l, z};
    endfunction

    function automatic logic do_act(logic [1:0] c, logic cur);
        case (c)
            2'd0: return cur;
            2'd1: return ~cur;
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic clr_counts();
        for (int i = 0; i < 6; i++) ev_cnt[i] = 0;
    endtask

    // One cycle: compare at the falling edge, advance the model at the rising edge.
    task automatic step(string tag);
        logic [5:0]    e;
        logic [1:0]    c;
        logic [CW-1:0] nc;
        logic          nd;
        logic          np;
        #1;
        e[5] = en && (m_cnt == 0);
        e[4] = en && (m_cnt == ld);
        e[3] = en && (m_cnt == ca) && m_dir;
        e[2] = en && (m_cnt == ca) && !m_dir;
        e[1] = en && (m_cnt == cb) && m_dir;
        e[0] = en && (m_cnt == cb) && !m_dir;
        check(tag, {1'b0, pwm, ez, el, eau, ead, ebu, ebd}, {1'b0, m_pwm, e});
        last_ev = {ez, el, eau, ead, ebu, ebd};
        for (int i = 0; i < 6; i++) if (last_ev[i]) ev_cnt[i]++;
        if (e[5])      c = act[1:0];
        else if (e[4]) c = act[3:2];
        else if (e[1]) c = act[9:8];
        else if (e[0]) c = act[11:10];
        else if (e[3]) c = act[5:4];
        else if (e[2]) c = act[7:6];
        else           c = 2'd0;
        np = do_act(c, m_pwm);
        nc = m_cnt; nd = m_dir;
        if (!en) begin
            nc = ud ? '0 : ld; nd = ud;
        end else if (!ud) begin
            nd = 1'b0; nc = (m_cnt == 0) ? ld : m_cnt - 1;
        end else if (m_dir) begin
            if (m_cnt >= ld) begin nd = 1'b0; nc = (ld == 0) ? '0 : ld - 1; end
            else nc = m_cnt + 1;
        end else begin
            if (m_cnt == 0) begin nd = 1'b1; nc = (ld == 0) ? '0 : CW'(1); end
            else nc = m_cnt - 1;
        end
        @(posedge clk);
        m_cnt = nc; m_dir = nd; m_pwm = np;
        @(negedge clk);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; act = '0;
        repeat (2) @(negedge clk);
        #1;
        check("R1", {1'b0, pwm, ez, el, eau, ead, ebu, ebd}, 8'h00);
        rst_n = 1'b1;
        m_cnt = '0; m_dir = 1'b1; m_pwm = 1'b0;
        clr_counts();
    endtask

    // R1: zero action word never moves the output.
    task automatic t_quiet();
        do_reset();
        ud = 1'b0; ld = 5; ca = 3; cb = 1; act = '0;
        run(1, "R1");
        en = 1'b1;
        run(20, "R1");
        check("R1", {7'd0, pwm}, 8'h00);
        en = 1'b0;
    endtask

    // R2: count-down period and event set.
    task automatic t_down();
        do_reset();
        ud = 1'b0; ld = 9; ca = 6; cb = 2;
        act = mk_act(2'd3, 2'd0, 2'd3, 2'd2, 2'd3, 2'd1);
        run(1, "R2");
        en = 1'b1; clr_counts();
        run(30, "R2");
        check("R2", 8'(ev_cnt[5]), 8'd3);
        check("R2", 8'(ev_cnt[4]), 8'd3);
        check("R2", 8'(ev_cnt[3] + ev_cnt[1]), 8'd0);
        check("R2", 8'(ev_cnt[2]), 8'd3);
        en = 1'b0;
    endtask

    // R3 / R11: up/down period, all six events, one pulse per crossing.
    task automatic t_updown();
        do_reset();
        ud = 1'b1; ld = 6; ca = 2; cb = 5;
        act = mk_act(2'd2, 2'd3, 2'd1, 2'd3, 2'd2, 2'd1);
        run(1, "R3");
        en = 1'b1; clr_counts();
        run(36, "R3");
        check("R3", 8'(ev_cnt[5]), 8'd3);
        check("R3", 8'(ev_cnt[4]), 8'd3);
        check("R11", 8'(ev_cnt[3]), 8'd3);
        check("R11", 8'(ev_cnt[2]), 8'd3);
        check("R11", 8'(ev_cnt[1]), 8'd3);
        check("R11", 8'(ev_cnt[0]), 8'd3);
        en = 1'b0;
    endtask

    // R4 / R9: each code, and the one-edge delay after a zero pulse.
    task automatic t_codes();
        for (int code = 1; code < 4; code++) begin
            do_reset();
            ud = 1'b0; ld = 3; ca = 9; cb = 9;
            act = mk_act(2'(code), 2'd0, 2'd0, 2'd0, 2'd0, 2'd0);
            run(1, "R4");
            en = 1'b1;
            run(3, "R4");
            for (int k = 0; k < 3; k++) begin
                logic pre;
                pre = pwm;
                step("R9");
                check("R9", {6'd0, last_ev[5], pwm},
                      {6'd0, 1'b1, do_act(2'(code), pre)});
                run(3, "R4");
            end
            en = 1'b0;
        end
    endtask

    // R5: each field acts only through its own event.
    task automatic t_fields();
        for (int idx = 0; idx < 6; idx++) begin
            do_reset();
            ud = 1'b1; ld = 4; ca = 1; cb = 3;
            act = 12'(3) << (2 * idx);
            run(1, "R5");
            en = 1'b1;
            run(10, "R5");
            check("R5", {7'd0, pwm}, 8'h01);
            en = 1'b0;
        end
    endtask

    // R6: zero/load beat coincident compare events.
    task automatic t_prio_zl();
        do_reset();
        ud = 1'b1; ld = 6; ca = 0; cb = 6;
        act = mk_act(2'd2, 2'd3, 2'd3, 2'd3, 2'd2, 2'd2);
        run(1, "R6");
        en = 1'b1;
        run(30, "R6");
        en = 1'b0;
    endtask

    // R7: B beats A in both directions.
    task automatic t_prio_ba();
        do_reset();
        ud = 1'b1; ld = 7; ca = 4; cb = 4;
        act = mk_act(2'd0, 2'd0, 2'd3, 2'd1, 2'd2, 2'd3);
        run(1, "R7");
        en = 1'b1;
        run(24, "R7");
        en = 1'b0;
        do_reset();
        ud = 1'b0; ld = 7; ca = 4; cb = 4;
        act = mk_act(2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0);
        run(1, "R7");
        en = 1'b1;
        run(16, "R7");
        check("R7", {7'd0, pwm}, 8'h00);
        en = 1'b0;
    endtask

    // R8: load of zero, zero action wins over load action.
    task automatic t_load0();
        do_reset();
        ud = 1'b0; ld = 0; ca = 5; cb = 5;
        act = mk_act(2'd3, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0);
        run(1, "R8");
        en = 1'b1;
        run(6, "R8");
        check("R8", {7'd0, pwm}, 8'h01);
        en = 1'b0;
    endtask

    // R10: idle freezes output and silences events, then restarts cleanly.
    task automatic t_disable();
        logic pre;
        do_reset();
        ud = 1'b1; ld = 5; ca = 2; cb = 3;
        act = mk_act(2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd1);
        run(1, "R10");
        en = 1'b1;
        run(13, "R10");
        en = 1'b0; pre = pwm; clr_counts();
        run(8, "R10");
        check("R10", {7'd0, pwm}, {7'd0, pre});
        check("R10", 8'(ev_cnt[0] + ev_cnt[1] + ev_cnt[2] + ev_cnt[3] + ev_cnt[4] + ev_cnt[5]), 8'd0);
        en = 1'b1;
        run(12, "R10");
        en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_quiet();
        t_down();
        t_updown();
        t_codes();
        t_fields();
        t_prio_zl();
        t_prio_ba();
        t_load0();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule